// File: doc/BRIEF.md
# NAND Boot Block Search Loader

This controller runs once after reset is released. It walks the blocks of an 8-bit NAND device, starting at block 0, until it finds one whose first two pages both carry an intact bad-block marker in their spare areas. It then copies 4 KiB of boot data from the pages of that block into a byte-wide local buffer. Spare bytes are never written to the buffer.

The device is reached through a simplified read port. The controller issues a one-cycle request that names the block, the page, and whether the data or the spare area is wanted. The device answers with a byte stream qualified by a valid strobe. An external checker reports one ECC verdict per 512-byte region. An input selects small-page geometry (512 data and 16 spare bytes per page) or large-page geometry (2048 data and 64 spare bytes per page). While loading, the controller holds the device write-protect pin low. It releases the pin only once the image is complete. An uncorrectable region stops the load and raises a reset request instead.

Top module: `nand_boot_loader`

## Requirements
- R1: While reset is high, `done`, `reset_req`, `buf_we` and `nand_wp_n` are low. After reset, the first read request is a spare-area read (`nand_rd_spare`=1) of block 0, page 0.
- R2: For each candidate block, the spare areas of pages 0 and 1 are read (spare reads only ever name page 0 or 1). The block is accepted only if both marker bytes equal 0xFF.
- R3: The marker is spare byte offset 5 when `large_page`=0 and spare byte offset 0 when `large_page`=1. All other spare bytes have no influence on the verdict.
- R4: A rejected block is followed by a check of the next block index (+1). The search has no retry limit.
- R5: `boot_block` equals the accepted block index from the end of the search onward and does not change afterwards.
- R6: Data pages 0, 1, 2, … of the accepted block are read in order. Small-page geometry takes 8 pages and large-page geometry takes 2. Exactly 4096 bytes are written, at addresses 0 to 4095 in increasing order. The byte at column c of page p goes to address p*page_data_size+c.
- R7: With `ecc_en`=1, `ecc_status` is taken on each `ecc_valid` pulse: 00 means clean, 01 means corrected, and any value with bit 1 set means uncorrectable. An uncorrectable verdict stops the load within two clock edges and sets `reset_req`, which stays high. After that, no buffer write occurs and `done` never rises. With no uncorrectable verdict, `done` waits until all 8 region verdicts have arrived.
- R8: With `ecc_en`=0, `ecc_valid` and `ecc_status` are ignored: `reset_req` stays low and the load completes.
- R9: `done` rises after the last buffer write (with ECC disabled, on the next cycle) and stays high. `nand_wp_n` is low (protected) exactly while `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| large_page | input | 1 | 0 selects small-page geometry, 1 selects large-page geometry |
| ecc_en | input | 1 | Enables use of the region ECC verdicts |
| nand_rd_req | output | 1 | One-cycle read request |
| nand_rd_spare | output | 1 | 1 requests the spare area, 0 requests the data area |
| nand_rd_block | output | 16 | Block index of the request |
| nand_rd_page | output | 6 | Page index within the block |
| nand_valid | input | 1 | Read byte strobe |
| nand_byte | input | 8 | Read byte |
| ecc_valid | input | 1 | Region verdict strobe |
| ecc_status | input | 2 | Region verdict code |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 12 | Buffer byte address |
| buf_data | output | 8 | Buffer write byte |
| boot_block | output | 16 | Selected block index |
| done | output | 1 | Image complete (sticky) |
| nand_wp_n | output | 1 | Device write-protect, low means protected |
| reset_req | output | 1 | Reset request after an uncorrectable region (sticky) |

## Verification
The assertions assume the following about the inputs: `large_page` and `ecc_en` change only during reset, the device sends exactly the requested number of bytes only after a request, and at most one ECC verdict arrives per completed region. The bench's device model keeps within these rules. It holds the geometry and ECC enable constant between resets and streams exactly one spare or data area per request, with a fixed latency and a regular one-in-four gap in the valid strobe. It emits one verdict three cycles after each 512-byte boundary of streamed data.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

  typedef enum logic [2:0] {
    ST_SPARE_REQ,
    ST_SPARE_RX,
    ST_DATA_REQ,
    ST_DATA_RX,
    ST_ECC_WAIT,
    ST_DONE,
    ST_HALT
  } ldr_state_t;

  localparam logic [1:0] ECC_CLEAN = 2'b00;
  localparam logic [1:0] ECC_FIXED = 2'b01;

  function automatic logic ecc_fatal_code(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/nbl_geometry.sv
module nbl_geometry #(
  parameter int SMALL_DATA  = 512,
  parameter int SMALL_SPARE = 16,
  parameter int LARGE_DATA  = 2048,
  parameter int LARGE_SPARE = 64,
  parameter int SMALL_MARK  = 5,
  parameter int LARGE_MARK  = 0,
  parameter int CNT_W       = 12
) (
  input  logic             clk,
  input  logic             large_page,
  output logic [CNT_W-1:0] data_last,
  output logic [CNT_W-1:0] spare_last,
  output logic [CNT_W-1:0] mark_off
);

  localparam logic [CNT_W-1:0] S_DLAST = CNT_W'(SMALL_DATA - 1);
  localparam logic [CNT_W-1:0] L_DLAST = CNT_W'(LARGE_DATA - 1);
  localparam logic [CNT_W-1:0] S_SLAST = CNT_W'(SMALL_SPARE - 1);
  localparam logic [CNT_W-1:0] L_SLAST = CNT_W'(LARGE_SPARE - 1);
  localparam logic [CNT_W-1:0] S_MARK  = CNT_W'(SMALL_MARK);
  localparam logic [CNT_W-1:0] L_MARK  = CNT_W'(LARGE_MARK);

  // Loaded every cycle, including during reset, so the values are settled
  // before the sequencer leaves reset.
  always_ff @(posedge clk) begin
    data_last  <= large_page ? L_DLAST : S_DLAST;
    spare_last <= large_page ? L_SLAST : S_SLAST;
    mark_off   <= large_page ? L_MARK  : S_MARK;
  end

endmodule

// File: rtl/nbl_ecc_track.sv
module nbl_ecc_track
  import nbl_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int RCNT_W = $clog2(NREG + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic       ecc_en,
  input  logic       ecc_valid,
  input  logic [1:0] ecc_status,
  output logic       all_seen,
  output logic       fatal
);

  localparam logic [RCNT_W-1:0] LAST_CNT = RCNT_W'(NREG);

  logic [RCNT_W-1:0] seen_q;
  logic              take;

  assign take     = arm && ecc_en && ecc_valid && (seen_q < LAST_CNT);
  assign all_seen = (seen_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      fatal  <= 1'b0;
    end else if (take) begin
      seen_q <= seen_q + 1'b1;
      if (ecc_fatal_code(ecc_status)) fatal <= 1'b1;
    end
  end

  AST_REGION_CAP: assert property (@(posedge clk) disable iff (rst)
    seen_q <= LAST_CNT); // R7
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal); // R7
  AST_ECC_OFF_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !ecc_en |-> !fatal && (seen_q == '0)); // R8

endmodule

// File: rtl/nbl_seq.sv
module nbl_seq
  import nbl_pkg::*;
#(
  parameter int BLK_W      = 16,
  parameter int PAGE_W     = 6,
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 12,
  parameter int BOOT_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_en,
  input  logic [CNT_W-1:0]  data_last,
  input  logic [CNT_W-1:0]  spare_last,
  input  logic [CNT_W-1:0]  mark_off,
  input  logic              nand_valid,
  input  logic [7:0]        nand_byte,
  input  logic              ecc_all_seen,
  input  logic              ecc_fatal,
  output logic              ecc_arm,
  output logic              nand_rd_req,
  output logic              nand_rd_spare,
  output logic [BLK_W-1:0]  nand_rd_block,
  output logic [PAGE_W-1:0] nand_rd_page,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic [BLK_W-1:0]  boot_block,
  output logic              done,
  output logic              nand_wp_n,
  output logic              reset_req
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BOOT_BYTES - 1);

  ldr_state_t        state_q;
  logic [BLK_W-1:0]  blk_q;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  col_q;
  logic [ADDR_W-1:0] wptr_q;
  logic              bad_q;
  logic              mark_hit;
  logic              bad_now;

  assign mark_hit   = (col_q == mark_off) && (nand_byte != 8'hFF);
  assign bad_now    = bad_q || mark_hit;
  assign boot_block = blk_q;
  assign ecc_arm    = (state_q == ST_DATA_REQ) || (state_q == ST_DATA_RX) ||
                      (state_q == ST_ECC_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_SPARE_REQ;
      blk_q         <= '0;
      page_q        <= '0;
      col_q         <= '0;
      wptr_q        <= '0;
      bad_q         <= 1'b0;
      nand_rd_req   <= 1'b0;
      nand_rd_spare <= 1'b0;
      nand_rd_block <= '0;
      nand_rd_page  <= '0;
      buf_we        <= 1'b0;
      buf_addr      <= '0;
      buf_data      <= '0;
      done          <= 1'b0;
      nand_wp_n     <= 1'b0;
      reset_req     <= 1'b0;
    end else begin
      nand_rd_req <= 1'b0;
      buf_we      <= 1'b0;
      case (state_q)
        ST_SPARE_REQ: begin
          nand_rd_req   <= 1'b1;
          nand_rd_spare <= 1'b1;
          nand_rd_block <= blk_q;
          nand_rd_page  <= page_q;
          col_q         <= '0;
          state_q       <= ST_SPARE_RX;
        end
        ST_SPARE_RX: begin
          if (nand_valid) begin
            col_q <= col_q + 1'b1;
            if (mark_hit) bad_q <= 1'b1;
            if (col_q == spare_last) begin
              if (page_q == '0) begin
                page_q  <= PAGE_W'(1);
                state_q <= ST_SPARE_REQ;
              end else if (bad_now) begin
                blk_q   <= blk_q + 1'b1;
                page_q  <= '0;
                bad_q   <= 1'b0;
                state_q <= ST_SPARE_REQ;
              end else begin
                page_q  <= '0;
                bad_q   <= 1'b0;
                state_q <= ST_DATA_REQ;
              end
            end
          end
        end
        ST_DATA_REQ: begin
          nand_rd_req   <= 1'b1;
          nand_rd_spare <= 1'b0;
          nand_rd_block <= blk_q;
          nand_rd_page  <= page_q;
          col_q         <= '0;
          state_q       <= ST_DATA_RX;
        end
        ST_DATA_RX: begin
          if (nand_valid) begin
            buf_we   <= 1'b1;
            buf_addr <= wptr_q;
            buf_data <= nand_byte;
            wptr_q   <= wptr_q + 1'b1;
            col_q    <= col_q + 1'b1;
            if (wptr_q == LAST_ADDR) begin
              state_q <= ecc_en ? ST_ECC_WAIT : ST_DONE;
            end else if (col_q == data_last) begin
              page_q  <= page_q + 1'b1;
              state_q <= ST_DATA_REQ;
            end
          end
        end
        ST_ECC_WAIT: begin
          if (ecc_all_seen) state_q <= ST_DONE;
        end
        ST_DONE: begin
          done      <= 1'b1;
          nand_wp_n <= 1'b1;
        end
        ST_HALT: begin
          reset_req <= 1'b1;
        end
        default: state_q <= ST_HALT;
      endcase

      // An uncorrectable region overrides whatever the load step chose.
      if (ecc_fatal && ecc_arm) begin
        state_q     <= ST_HALT;
        reset_req   <= 1'b1;
        buf_we      <= 1'b0;
        nand_rd_req <= 1'b0;
      end
    end
  end

  // Write counter kept only for the ordering checks below.
  logic [ADDR_W:0] wr_seen_q;
  always_ff @(posedge clk) begin
    if (rst) wr_seen_q <= '0;
    else if (buf_we) wr_seen_q <= wr_seen_q + 1'b1;
  end

  AST_FIRST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> blk_q == '0); // R1
  AST_SPARE_PAGES: assert property (@(posedge clk) disable iff (rst)
    nand_rd_req && nand_rd_spare |-> nand_rd_page <= PAGE_W'(1)); // R2
  AST_BLK_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(blk_q) |-> blk_q == $past(blk_q) + 1'b1); // R4
  AST_BLK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ecc_arm |=> $stable(blk_q)); // R5
  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> buf_addr == wr_seen_q[ADDR_W-1:0]); // R6
  AST_WRITE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> wr_seen_q < (ADDR_W+1)'(BOOT_BYTES)); // R6
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req && !buf_we && !done); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R9
  AST_WP_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    !done |-> !nand_wp_n); // R9

endmodule

// File: rtl/nand_boot_loader.sv
module nand_boot_loader
  import nbl_pkg::*;
#(
  parameter int PAGES_PER_BLOCK = 64,
  parameter int BLK_W           = 16,
  parameter int BOOT_BYTES      = 4096,
  parameter int REGION_BYTES    = 512,
  parameter int SMALL_DATA      = 512,
  parameter int SMALL_SPARE     = 16,
  parameter int LARGE_DATA      = 2048,
  parameter int LARGE_SPARE     = 64,
  parameter int SMALL_MARK      = 5,
  parameter int LARGE_MARK      = 0,
  localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK),
  localparam int ADDR_W         = $clog2(BOOT_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              large_page,
  input  logic              ecc_en,
  output logic              nand_rd_req,
  output logic              nand_rd_spare,
  output logic [BLK_W-1:0]  nand_rd_block,
  output logic [PAGE_W-1:0] nand_rd_page,
  input  logic              nand_valid,
  input  logic [7:0]        nand_byte,
  input  logic              ecc_valid,
  input  logic [1:0]        ecc_status,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic [BLK_W-1:0]  boot_block,
  output logic              done,
  output logic              nand_wp_n,
  output logic              reset_req
);

  localparam int MAX_AREA = (LARGE_DATA > SMALL_DATA) ? LARGE_DATA : SMALL_DATA;
  localparam int CNT_W    = $clog2(MAX_AREA) + 1;
  localparam int NREG     = BOOT_BYTES / REGION_BYTES;

  logic [CNT_W-1:0] data_last;
  logic [CNT_W-1:0] spare_last;
  logic [CNT_W-1:0] mark_off;
  logic             ecc_arm;
  logic             ecc_all_seen;
  logic             ecc_fatal;

  nbl_geometry #(
    .SMALL_DATA (SMALL_DATA),
    .SMALL_SPARE(SMALL_SPARE),
    .LARGE_DATA (LARGE_DATA),
    .LARGE_SPARE(LARGE_SPARE),
    .SMALL_MARK (SMALL_MARK),
    .LARGE_MARK (LARGE_MARK),
    .CNT_W      (CNT_W)
  ) u_geom (
    .clk       (clk),
    .large_page(large_page),
    .data_last (data_last),
    .spare_last(spare_last),
    .mark_off  (mark_off)
  );

  nbl_ecc_track #(
    .NREG(NREG)
  ) u_ecc (
    .clk       (clk),
    .rst       (rst),
    .arm       (ecc_arm),
    .ecc_en    (ecc_en),
    .ecc_valid (ecc_valid),
    .ecc_status(ecc_status),
    .all_seen  (ecc_all_seen),
    .fatal     (ecc_fatal)
  );

  nbl_seq #(
    .BLK_W     (BLK_W),
    .PAGE_W    (PAGE_W),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .BOOT_BYTES(BOOT_BYTES)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .ecc_en       (ecc_en),
    .data_last    (data_last),
    .spare_last   (spare_last),
    .mark_off     (mark_off),
    .nand_valid   (nand_valid),
    .nand_byte    (nand_byte),
    .ecc_all_seen (ecc_all_seen),
    .ecc_fatal    (ecc_fatal),
    .ecc_arm      (ecc_arm),
    .nand_rd_req  (nand_rd_req),
    .nand_rd_spare(nand_rd_spare),
    .nand_rd_block(nand_rd_block),
    .nand_rd_page (nand_rd_page),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .buf_data     (buf_data),
    .boot_block   (boot_block),
    .done         (done),
    .nand_wp_n    (nand_wp_n),
    .reset_req    (reset_req)
  );

endmodule

// File: tb/nand_boot_loader_test.sv
`timescale 1ns/1ps
module nand_boot_loader_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        large_page = 1'b0;
  logic        ecc_en = 1'b0;
  logic        nand_rd_req;
  logic        nand_rd_spare;
  logic [15:0] nand_rd_block;
  logic [5:0]  nand_rd_page;
  logic        nand_valid = 1'b0;
  logic [7:0]  nand_byte = 8'h00;
  logic        ecc_valid = 1'b0;
  logic [1:0]  ecc_status = 2'b00;
  logic        buf_we;
  logic [11:0] buf_addr;
  logic [7:0]  buf_data;
  logic [15:0] boot_block;
  logic        done;
  logic        nand_wp_n;
  logic        reset_req;

  always #2 clk = ~clk;

  nand_boot_loader uut (
    .clk(clk), .rst(rst), .large_page(large_page), .ecc_en(ecc_en),
    .nand_rd_req(nand_rd_req), .nand_rd_spare(nand_rd_spare),
    .nand_rd_block(nand_rd_block), .nand_rd_page(nand_rd_page),
    .nand_valid(nand_valid), .nand_byte(nand_byte),
    .ecc_valid(ecc_valid), .ecc_status(ecc_status),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .boot_block(boot_block), .done(done), .nand_wp_n(nand_wp_n),
    .reset_req(reset_req)
  );

  int n_checks = 0;
  int n_err = 0;

  // Test configuration
  int          exp_blk = 0;
  logic [15:0] bad_p0 = '0;
  logic [15:0] bad_p1 = '0;
  int          fatal_region = -1;
  logic [1:0]  ecc_fill = 2'b00;

  // Reference-model state
  int exp_addr = 0;
  int writes = 0;
  int ecc_fired = 0;
  bit first_req = 1'b1;
  bit prev_we = 1'b0;
  bit prev_done = 1'b0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dsz();  return large_page ? 2048 : 512; endfunction
  function automatic int ssz();  return large_page ? 64 : 16;   endfunction
  function automatic int moff(); return large_page ? 0 : 5;     endfunction

  function automatic logic [7:0] pat(input int b, input int p, input int c);
    return 8'((b * 29 + p * 77 + c * 3 + (c >> 8)) & 255);
  endfunction

  function automatic logic [7:0] spare_byte(input int b, input int p, input int c);
    if (c != moff()) return 8'h00;
    if (b < 16 && p == 0 && bad_p0[b]) return 8'h3C;
    if (b < 16 && p == 1 && bad_p1[b]) return 8'hFE;
    return 8'hFF;
  endfunction

  // Device and ECC-checker model
  int m_rem = 0, m_lat = 0, m_blk = 0, m_pg = 0, m_col = 0, m_gap = 0;
  int streamed = 0, ecc_cd = 0;
  bit m_sp = 1'b0;
  logic [1:0] ecc_code = 2'b00;

  initial begin
    forever begin
      @(negedge clk);
      nand_valid = 1'b0;
      ecc_valid  = 1'b0;
      if (rst) begin
        m_rem = 0; m_lat = 0; streamed = 0; ecc_cd = 0; m_gap = 0;
      end else begin
        if (ecc_cd > 0) begin
          ecc_cd--;
          if (ecc_cd == 0) begin
            ecc_valid  = 1'b1;
            ecc_status = ecc_code;
            ecc_fired++;
          end
        end
        if (nand_rd_req) begin
          m_sp  = nand_rd_spare;
          m_blk = int'(nand_rd_block);
          m_pg  = int'(nand_rd_page);
          m_col = 0;
          m_rem = nand_rd_spare ? ssz() : dsz();
          m_lat = 2;
        end else if (m_lat > 0) begin
          m_lat--;
        end else if (m_rem > 0) begin
          m_gap++;
          if (m_gap % 4 != 3) begin
            nand_valid = 1'b1;
            nand_byte  = m_sp ? spare_byte(m_blk, m_pg, m_col) : pat(m_blk, m_pg, m_col);
            m_col++;
            m_rem--;
            if (!m_sp) begin
              streamed++;
              if (streamed % 512 == 0) begin
                ecc_cd = 3;
                if (!ecc_en) ecc_code = ecc_fill;
                else if (streamed / 512 - 1 == fatal_region) ecc_code = 2'b10;
                else ecc_code = ((streamed / 512) % 2 == 0) ? 2'b00 : 2'b01;
              end
            end
          end
        end
      end
    end
  end

  // Per-cycle monitor compared with the reference expectations
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && !rst) begin
        if (nand_rd_req && first_req) begin
          chk(nand_rd_spare && nand_rd_block == 16'd0 && nand_rd_page == 6'd0,
              "R1 first request", int'(nand_rd_block), 0);
          first_req = 1'b0;
        end
        if (nand_rd_req && nand_rd_spare)
          chk(nand_rd_page <= 6'd1, "R2 spare page", int'(nand_rd_page), 1);
        if (buf_we) begin
          chk(int'(buf_addr) == exp_addr, "R6 address", int'(buf_addr), exp_addr);
          chk(buf_data == pat(exp_blk, exp_addr / dsz(), exp_addr % dsz()),
              "R6 data", int'(buf_data), int'(pat(exp_blk, exp_addr / dsz(), exp_addr % dsz())));
          exp_addr++;
          writes++;
        end
        chk(nand_wp_n == done, "R9 write protect", int'(nand_wp_n), int'(done));
        if (reset_req)
          chk(!buf_we && !done, "R7 quiet after halt", int'(buf_we), 0);
        if (prev_done)
          chk(done, "R9 done sticky", int'(done), 1);
        if (done && !prev_done) begin
          chk(writes == 4096, "R6 write total", writes, 4096);
          if (!ecc_en) chk(prev_we, "R9 done after last write", int'(prev_we), 1);
          else chk(ecc_fired == 8, "R7 all verdicts before done", ecc_fired, 8);
        end
        prev_we   = buf_we;
        prev_done = done;
      end
    end
  end

  task automatic run_test(input bit lp, input bit ee, input logic [15:0] b0,
                          input logic [15:0] b1, input int freg, input logic [1:0] fill,
                          input int blk, input bit expect_halt, input string name);
    int cyc;
    @(negedge clk);
    rst = 1'b1;
    mon_on = 1'b0;
    large_page = lp; ecc_en = ee;
    bad_p0 = b0; bad_p1 = b1; fatal_region = freg; ecc_fill = fill; exp_blk = blk;
    exp_addr = 0; writes = 0; ecc_fired = 0; first_req = 1'b1;
    prev_we = 1'b0; prev_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !reset_req && !buf_we && !nand_wp_n, {"R1 reset state ", name},
        int'({done, reset_req, buf_we, nand_wp_n}), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    cyc = 0;
    while (!done && !reset_req && cyc < 30000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 30000, {"R4 search/load finished ", name}, cyc, 30000);
    repeat (30) @(negedge clk);
    chk(boot_block == 16'(blk), {"R5 boot block ", name}, int'(boot_block), blk);
    if (expect_halt) begin
      chk(reset_req && !done && !nand_wp_n, {"R7 halted ", name}, int'(reset_req), 1);
      chk(writes >= 2048 && writes <= 2050, {"R7 writes before halt ", name}, writes, 2048);
    end else begin
      chk(done && nand_wp_n && !reset_req, {"R9 completed ", name}, int'(done), 1);
      chk(writes == 4096, {"R6 total after idle ", name}, writes, 4096);
      if (!ee) chk(!reset_req, {"R8 verdicts ignored ", name}, int'(reset_req), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    // R2 R4: blk0 page1 bad, blk1 page0 bad, blk2 good; small page, ECC on
    run_test(1'b0, 1'b1, 16'h0002, 16'h0001, -1, 2'b00, 2, 1'b0, "small ecc");
    // R3 R8: large page, blk0 bad at offset 0, offset 5 zero elsewhere; ECC off
    run_test(1'b1, 1'b0, 16'h0001, 16'h0000, -1, 2'b10, 1, 1'b0, "large no-ecc");
    // R3 R7: small page, spare byte 0 zero but offset 5 intact; region 3 fatal
    run_test(1'b0, 1'b1, 16'h0000, 16'h0000, 3, 2'b00, 0, 1'b1, "small fatal");
    // R4: five rejected blocks before block 5; large page, ECC on
    run_test(1'b1, 1'b1, 16'h0015, 16'h000A, -1, 2'b00, 5, 1'b0, "large long search");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule